// File: doc/BRIEF.md
# Banked Interrupt Controller With Event Latching

This block collects up to 64 interrupt inputs, grouped into banks of 32, and presents one interrupt request line to a processor together with the number of the source that should be serviced first. Each input passes through a synchronizer. A rising edge on an enabled input is held in a per-source event bit. The bit stays set until software clears it by writing a one to the matching position of the bank's acknowledge register.

Sources marked as level-type by a parameter also stay pending for as long as their input is high and they are enabled. The raw synchronized input state can be read at any time, whether or not the source is enabled. Software reaches the block through a plain synchronous register port: a write strobe with address and data, and a read strobe whose data appears on the next cycle.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every enable bit and every event bit is zero, and `irq_o`, `vec_vld_o` and `vec_o` are zero.
- R2: Addresses are byte addresses and must be word-aligned. Sources 0–31 use the bank at 0x20 and sources 32–63 use the bank at 0x10. Within a bank the registers sit at these offsets: event at +0x0 (read-only), enable at +0x4, acknowledge at +0x8 (write-only, reads as zero) and level at +0xC (read-only). Read data is registered and is valid on the clock after `reg_rd_i`.
- R3: The enable register reads back exactly the value last written to it.
- R4: An event bit is set by a rising edge of the synchronized input, but only while that source's enable bit is set. An input change is seen by the event bit after the third rising clock edge, when SYNC_STAGES is 2. The bit then holds after the input falls, until it is acknowledged.
- R5: Writing a one to a bit of the acknowledge register clears that source's event bit. Writing zero bits changes nothing.
- R6: Setting the enable bit of an edge-type source whose input is already high sets no event bit and raises no request.
- R7: The level register returns the synchronized state of every input, whether or not the input is enabled.
- R8: A source is pending when (event OR (level AND level-type)) AND enable is set for it. A level-type source therefore stays pending after acknowledge while its input stays high, and it becomes pending as soon as it is enabled while high.
- R9: `vec_o` gives the highest-numbered pending source, so the upper bank wins over the lower bank. `vec_vld_o` and `irq_o` are high exactly when some source is pending. `vec_o` is zero when none is pending.
- R10: When a rising edge is latched in the same cycle that software acknowledges that bit, the edge wins and the event bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 64 | Raw interrupt inputs, one per source |
| reg_addr_i | input | 6 | Register byte address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 6 | Number of the winning pending source |
| vec_vld_o | output | 1 | High when `vec_o` names a pending source |

## Verification
The bench builds the block with two banks and a two-stage synchronizer. It marks source 2 of the lower bank and source 32, the first source of the upper bank, as level-type, and leaves every other source edge-type. With this mix one run covers edge latching and level-held pending in both banks. It also covers the difference between enabling an edge-type input that is already high (no request) and enabling a level-type one (immediate request). The fixed two-stage synchronizer lets the bench place an acknowledge write on exactly the edge that latches a new event, which exercises the edge-wins rule.

// File: rtl/birq_pkg.sv
package birq_pkg;
  // Register slot within one bank, taken from byte address bits [3:2]
  typedef enum logic [1:0] {
    RS_EVENT  = 2'd0,
    RS_ENABLE = 2'd1,
    RS_ACK    = 2'd2,
    RS_LEVEL  = 2'd3
  } reg_sel_e;

  localparam int OFS_W = 4;  // byte offset bits covering one bank
endpackage

// File: rtl/birq_sync.sv
module birq_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= stg_d[s];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/birq_bank.sv
module birq_bank #(
  parameter int           W        = 32,
  parameter logic [W-1:0] LVL_TYPE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic         en_we_i,
  input  logic         ack_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q, evt_q, en_q;
  logic [W-1:0] rise, ack_mask, evt_d;

  // edge detection on the synchronized input
  assign rise     = lvl_i & ~prev_q;
  assign ack_mask = ack_we_i ? wdata_i : '0;

  // a new edge is merged after the clear, so it survives a same-cycle ack
  always_comb begin
    evt_d = (evt_q & ~ack_mask) | (rise & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
      en_q   <= '0;
    end else begin
      prev_q <= lvl_i;
      evt_q  <= evt_d;
      if (en_we_i) en_q <= wdata_i;
    end
  end

  assign evt_o  = evt_q;
  assign en_o   = en_q;
  assign pend_o = (evt_q | (lvl_i & LVL_TYPE)) & en_q;

  // R3
  en_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_we_i |=> (en_q == $past(wdata_i)));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we_i |=> ((evt_q & $past(wdata_i & ~rise)) == '0));

  // R4
  no_masked_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q != ~en_q) |=> ((evt_q & ~$past(evt_q) & ~$past(en_q)) == '0));

  // R10
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we_i && |(rise & en_q & wdata_i)) |=>
      ((evt_q & $past(rise & en_q)) == $past(rise & en_q)));
endmodule

// File: rtl/birq_prio.sv
module birq_prio #(
  parameter int N  = 64,
  parameter int VW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  pend_i,
  output logic [VW-1:0] vec_o,
  output logic          vld_o
);
  // later (higher) indices overwrite lower ones: highest number wins
  always_comb begin
    vec_o = '0;
    vld_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (pend_i[i]) begin
        vec_o = VW'(i);
        vld_o = 1'b1;
      end
    end
  end

  // R9
  win_highest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> ((pend_i >> vec_o) == N'(1)));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> (pend_i == '0 && vec_o == '0));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import birq_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int BANK_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 6,
  parameter int BANK0_BASE  = 32'h20,
  parameter int BANK_STEP   = 32'h10,
  parameter logic [NUM_BANKS*BANK_W-1:0] LEVEL_TYPE = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic [ADDR_W-1:0]           reg_addr_i,
  input  logic                        reg_wr_i,
  input  logic                        reg_rd_i,
  input  logic [BANK_W-1:0]           reg_wdata_i,
  output logic [BANK_W-1:0]           reg_rdata_o,
  output logic                        irq_o,
  output logic [$clog2(NUM_BANKS*BANK_W)-1:0] vec_o,
  output logic                        vec_vld_o
);
  localparam int NSRC = NUM_BANKS * BANK_W;
  localparam int VW   = $clog2(NSRC);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NSRC-1:0] src_sync;
  birq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .d_i  (src_i),
    .q_o  (src_sync)
  );

  reg_sel_e sel;
  logic     aligned;
  assign sel     = reg_sel_e'(reg_addr_i[3:2]);
  assign aligned = (reg_addr_i[1:0] == 2'b00);

  logic [NUM_BANKS-1:0] hit, en_we, ack_we;
  logic [BANK_W-1:0]    evt_w  [NUM_BANKS];
  logic [BANK_W-1:0]    en_w   [NUM_BANKS];
  logic [BANK_W-1:0]    pend_w [NUM_BANKS];
  logic [NSRC-1:0]      pend_all;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BANK0_BASE - b * BANK_STEP);

    assign hit[b]    = aligned && (reg_addr_i[ADDR_W-1:OFS_W] == BASE[ADDR_W-1:OFS_W]);
    assign en_we[b]  = reg_wr_i && hit[b] && (sel == RS_ENABLE);
    assign ack_we[b] = reg_wr_i && hit[b] && (sel == RS_ACK);

    birq_bank #(
      .W       (BANK_W),
      .LVL_TYPE(LEVEL_TYPE[b*BANK_W +: BANK_W])
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_q),
      .lvl_i   (src_sync[b*BANK_W +: BANK_W]),
      .en_we_i (en_we[b]),
      .ack_we_i(ack_we[b]),
      .wdata_i (reg_wdata_i),
      .evt_o   (evt_w[b]),
      .en_o    (en_w[b]),
      .pend_o  (pend_w[b])
    );

    assign pend_all[b*BANK_W +: BANK_W] = pend_w[b];
  end

  // read path
  logic [BANK_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (hit[b]) begin
        case (sel)
          RS_EVENT:  rd_mux = evt_w[b];
          RS_ENABLE: rd_mux = en_w[b];
          RS_LEVEL:  rd_mux = src_sync[b*BANK_W +: BANK_W];
          default:   rd_mux = '0;
        endcase
      end
    end
  end

  logic [BANK_W-1:0] rdata_q;
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rdata_q <= '0;
    end else if (reg_rd_i) begin
      rdata_q <= rd_mux;
    end
  end
  assign reg_rdata_o = rdata_q;

  logic vld;
  birq_prio #(.N(NSRC), .VW(VW)) u_prio (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .pend_i(pend_all),
    .vec_o (vec_o),
    .vld_o (vld)
  );

  assign vec_vld_o = vld;
  assign irq_o     = vld;

  // R2
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (reg_rd_i && |hit && sel == RS_ACK) |=> (reg_rdata_o == '0));

  // R9
  irq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    irq_o == (pend_all != '0));
endmodule

// File: tb/banked_irq_ctrl_tb.sv
`timescale 1ns/1ps
module banked_irq_ctrl_tb;
  localparam logic [63:0] LVL = 64'h0000_0001_0000_0004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, vld;
  logic [5:0]  vec;

  always #2 clk = ~clk;

  banked_irq_ctrl #(.LEVEL_TYPE(LVL)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .vec_o(vec), .vec_vld_o(vld)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // scoreboard for register reads
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;
  logic [31:0] e_val;
  string       e_tag;

  always @(posedge clk) rd_seen <= rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      e_val = exp_q.pop_front();
      e_tag = tag_q.pop_front();
      n_chk++;
      if (rdata !== e_val) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected %h", e_tag, rdata, e_val);
      end
    end
  end

  // all tasks start and end on a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [5:0] a, input logic [31:0] ex, input string tag);
    addr = a; rd = 1'b1;
    exp_q.push_back(ex);
    tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic chk_out(input logic ei, input logic [5:0] ev, input string tag);
    n_chk++;
    if (irq !== ei || vld !== ei || vec !== ev) begin
      n_fail++;
      $display("FAIL %s: irq=%b vld=%b vec=%0d expected irq=%b vld=%b vec=%0d",
               tag, irq, vld, vec, ei, ei, ev);
    end
  endtask

  task automatic set_src(input int i, input logic v);
    src[i] = v;
    idle(4);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk_out(1'b0, 6'd0, "R1 reset outputs");
    rd_reg(6'h24, 32'h0, "R1 enable0 after reset");
    rd_reg(6'h20, 32'h0, "R1 event0 after reset");
    rd_reg(6'h14, 32'h0, "R1 enable1 after reset");

    // R3 enable readback, R2 bank placement
    wr_reg(6'h14, 32'h8000_0001);
    wr_reg(6'h24, 32'h0000_0030);
    rd_reg(6'h14, 32'h8000_0001, "R3 enable1 readback");
    rd_reg(6'h24, 32'h0000_0030, "R3 enable0 readback");

    // R4 edge latch and hold
    set_src(5, 1'b1);
    rd_reg(6'h20, 32'h0000_0020, "R4 event0 after edge");
    chk_out(1'b1, 6'd5, "R4 request from src5");
    set_src(5, 1'b0);
    rd_reg(6'h20, 32'h0000_0020, "R4 event held after input low");

    // R9 priority
    set_src(4, 1'b1);
    rd_reg(6'h20, 32'h0000_0030, "R4 event0 two sources");
    chk_out(1'b1, 6'd5, "R9 higher of src4/src5");
    set_src(63, 1'b1);
    chk_out(1'b1, 6'd63, "R9 upper bank wins");
    rd_reg(6'h1C, 32'h8000_0000, "R7 level1 readback");
    rd_reg(6'h18, 32'h0, "R2 ack reads zero");
    set_src(63, 1'b0);
    set_src(4, 1'b0);

    // R5 acknowledge
    wr_reg(6'h28, 32'h0000_0020);
    idle(1);
    rd_reg(6'h20, 32'h0000_0010, "R5 ack clears src5 only");
    chk_out(1'b1, 6'd63, "R5 src63 still wins");
    wr_reg(6'h18, 32'h0);
    idle(1);
    rd_reg(6'h10, 32'h8000_0000, "R5 zero ack no effect");
    wr_reg(6'h18, 32'h8000_0000);
    idle(1);
    chk_out(1'b1, 6'd4, "R5 after ack src63");
    wr_reg(6'h28, 32'h0000_0010);
    idle(1);
    chk_out(1'b0, 6'd0, "R9 nothing pending");

    // R7 level regardless of enable, R4 masked edge ignored
    set_src(7, 1'b1);
    rd_reg(6'h2C, 32'h0000_0080, "R7 level0 of disabled src7");
    rd_reg(6'h20, 32'h0, "R4 masked edge not latched");
    chk_out(1'b0, 6'd0, "R4 masked edge no request");

    // R6 enabling an edge-type source while high
    wr_reg(6'h24, 32'h0000_00B0);
    idle(4);
    rd_reg(6'h20, 32'h0, "R6 no event on enable");
    chk_out(1'b0, 6'd0, "R6 no request on enable");
    set_src(7, 1'b0);
    set_src(7, 1'b1);
    chk_out(1'b1, 6'd7, "R4 new edge after enable");
    set_src(7, 1'b0);
    wr_reg(6'h28, 32'h0000_0080);
    idle(1);

    // R8 level-type source in upper bank
    set_src(32, 1'b1);
    chk_out(1'b1, 6'd32, "R8 level src32 pending");
    wr_reg(6'h18, 32'h0000_0001);
    idle(2);
    rd_reg(6'h10, 32'h0, "R5 event1 cleared");
    chk_out(1'b1, 6'd32, "R8 level src32 held after ack");
    set_src(32, 1'b0);
    chk_out(1'b0, 6'd0, "R8 level src32 released");

    // R8 level-type source enabled while high
    set_src(2, 1'b1);
    chk_out(1'b0, 6'd0, "R8 disabled level src2");
    rd_reg(6'h2C, 32'h0000_0004, "R7 level0 src2");
    wr_reg(6'h24, 32'h0000_00B4);
    idle(1);
    chk_out(1'b1, 6'd2, "R8 level src2 pends on enable");
    set_src(2, 1'b0);
    chk_out(1'b0, 6'd0, "R8 level src2 low");
    rd_reg(6'h20, 32'h0, "R4 src2 edge while disabled");

    // R10 edge and ack on the same edge
    src[4] = 1'b1;
    idle(2);
    wr_reg(6'h28, 32'h0000_0010);
    idle(2);
    rd_reg(6'h20, 32'h0000_0010, "R10 edge wins over ack");
    chk_out(1'b1, 6'd4, "R10 request kept");
    wr_reg(6'h28, 32'h0000_0010);
    idle(1);
    rd_reg(6'h20, 32'h0, "R5 later ack clears");
    chk_out(1'b0, 6'd0, "R5 idle at end");

    idle(3);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule